// File: doc/BRIEF.md
# TDM Channel Window Enable Generator

This block follows the position inside a 256-bit time-division frame and raises enable strobes during the time slots that a 4-bit timing code selects. The frame has 32 channels of 8 bits each. A bit clock advances the position by one bit per cycle. A frame pulse pins the position back to channel 0, bit 0. The selected windows are irregular:

- a leading part of channel 0 (1, 2, 6 or 7 bits);
- one whole channel (2, 3 or 4);
- a run of channels (2 to 3, or 2 to 4).

Each frame therefore carries between 1 and 24 enabled bits. Channel 1 carries a separate control stream, and the block never opens a window on it.

The transmit enable and the receive enable are the same strobe. A matching output-enable lets the serial driver release the line outside the window. The block also reports the current channel and bit index. A new timing code is taken only at a frame boundary, so a frame never carries a window that is cut short. The enables stay low from reset until the first frame pulse has been seen.

Top module: `tdm_window_gen`

## Requirements
- R1: While reset is high and after it, the outputs `tx_en`, `rx_en`, `out_en`, `chan_idx` and `bit_idx` are 0. The enables stay low until a frame pulse has been sampled, whatever code is applied.
- R2: The position advances in three ways:
  - A frame pulse sampled high at a clock edge makes the indices read channel 0, bit 0 after that edge.
  - Without a pulse, the bit index counts 0..7, and the channel index increments when the bit index passes 7.
  - After channel 31, bit 7, the position wraps to channel 0, bit 0.
- R3: Bit index 0 is the MSB, the first bit of a channel on the line. The code's low three bits select the channel-0 windows as follows:
  - 000 enables bit 0 of channel 0 only.
  - 001 enables bits 0 and 1 of channel 0.
- R4: Code 0010 enables bits 0 to 5 of channel 0, which is 6 bits. Code 1010 enables bits 0 to 6 of channel 0, which is 7 bits. No code enables bit 7 of channel 0.
- R5: The code's low three bits select a single whole channel (8 bits) as follows:
  - 011 selects channel 2.
  - 100 selects channel 3.
  - 101 selects channel 4.
- R6: Low bits 110 enable channels 2 and 3, which is 16 bits. Low bits 111 enable channels 2, 3 and 4, which is 24 bits.
- R7: No enable is ever high while `chan_idx` is 1.
- R8: `rx_en` and `out_en` always equal `tx_en`. `out_en` is low at every position outside the window.
- R9: The code is sampled only at a frame boundary. A boundary is the edge that moves the position to channel 0, bit 0, either through a pulse or through a wrap. A code change in mid-frame has no effect on the enables until the next boundary.
- R10: Bit 3 of the code (the top bit) has no effect for any low-bit value other than 010.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, one cycle per serial bit |
| rst | input | 1 | Synchronous active-high reset |
| frame_pulse | input | 1 | Frame start strobe, sampled at the rising edge |
| ctrl_code | input | 4 | Timing code; bit 3 is the 6/7-bit selector |
| tx_en | output | 1 | Transmit window enable |
| rx_en | output | 1 | Receive window enable |
| out_en | output | 1 | Serial output driver enable; low means the line is released |
| chan_idx | output | 5 | Channel number of the current bit |
| bit_idx | output | 3 | Bit number within the channel, 0 = MSB |

## Verification
Every output is a register that is loaded from the next-position logic. The indices and the enables for a position therefore appear one edge after the edge that sampled the frame pulse or the previous position. That same edge also captures a code that is driven together with a frame pulse. The bench drives inputs on the falling edge and samples on the next falling edge. Position k of a frame is therefore read exactly k+1 falling edges after the pulse was driven. A mid-frame code change is checked against the old window for the remaining bits of that frame, and against the new window from the wrap onward.

// File: rtl/tdmw_pkg.sv
package tdmw_pkg;

  typedef logic [3:0] tc_code_t;

  // channel assignments of the selectable windows
  localparam int unsigned SUB_CHAN  = 0;  // partial-channel window
  localparam int unsigned CTRL_CHAN = 1;  // never enabled
  localparam int unsigned RUN_FIRST = 2;  // first full channel of runs

  // Window membership for a position under a code.
  function automatic logic slot_hit(input tc_code_t code,
                                    input int unsigned chan,
                                    input int unsigned bitn);
    logic hit;
    hit = 1'b0;
    unique case (code[2:0])
      3'b000: hit = (chan == SUB_CHAN) && (bitn < 1);
      3'b001: hit = (chan == SUB_CHAN) && (bitn < 2);
      3'b010: hit = (chan == SUB_CHAN) && (bitn < (code[3] ? 7 : 6));
      3'b011: hit = (chan == RUN_FIRST);
      3'b100: hit = (chan == RUN_FIRST + 1);
      3'b101: hit = (chan == RUN_FIRST + 2);
      3'b110: hit = (chan >= RUN_FIRST) && (chan <= RUN_FIRST + 1);
      3'b111: hit = (chan >= RUN_FIRST) && (chan <= RUN_FIRST + 2);
      default: hit = 1'b0;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/tdmw_slot_counter.sv
module tdmw_slot_counter #(
  parameter int NUM_CHAN  = 32,
  parameter int CHAN_BITS = 8,
  localparam int CH_W = $clog2(NUM_CHAN),
  localparam int BT_W = $clog2(CHAN_BITS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            frame_pulse,
  output logic [CH_W-1:0] chan_q,
  output logic [BT_W-1:0] bit_q,
  output logic [CH_W-1:0] chan_d,
  output logic [BT_W-1:0] bit_d,
  output logic            boundary
);
  localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CHAN - 1);
  localparam logic [BT_W-1:0] LAST_BT = BT_W'(CHAN_BITS - 1);

  logic bit_wrap, frame_wrap;

  always_comb begin
    bit_wrap   = (bit_q == LAST_BT);
    frame_wrap = bit_wrap && (chan_q == LAST_CH);
    if (frame_pulse || frame_wrap) begin
      chan_d = '0;
      bit_d  = '0;
    end else if (bit_wrap) begin
      chan_d = chan_q + 1'b1;
      bit_d  = '0;
    end else begin
      chan_d = chan_q;
      bit_d  = bit_q + 1'b1;
    end
    boundary = frame_pulse || frame_wrap;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chan_q <= '0;
      bit_q  <= '0;
    end else begin
      chan_q <= chan_d;
      bit_q  <= bit_d;
    end
  end

  // R2: a sampled pulse restarts the frame
  p_pulse_restart_r2: assert property (@(posedge clk) disable iff (rst)
    frame_pulse |=> (chan_q == '0) && (bit_q == '0));

  // R2: bit index steps by one inside a channel
  p_bit_step_r2: assert property (@(posedge clk) disable iff (rst)
    (!frame_pulse && bit_q != LAST_BT) |=> (bit_q == $past(bit_q) + 1'b1)
                                        && $stable(chan_q));

  // R2: end of frame wraps to the start
  p_frame_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (!frame_pulse && bit_q == LAST_BT && chan_q == LAST_CH)
      |=> (chan_q == '0) && (bit_q == '0));

endmodule

// File: rtl/tdmw_code_latch.sv
module tdmw_code_latch
  import tdmw_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     frame_pulse,
  input  logic     boundary,
  input  tc_code_t code_in,
  output tc_code_t code_q,
  output tc_code_t code_d,
  output logic     synced_q,
  output logic     synced_d
);

  always_comb begin
    code_d   = boundary ? code_in : code_q;
    synced_d = synced_q | frame_pulse;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q   <= '0;
      synced_q <= 1'b0;
    end else begin
      code_q   <= code_d;
      synced_q <= synced_d;
    end
  end

  // R9: the active code holds between frame boundaries
  p_code_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !boundary |=> $stable(code_q));

  // R1: once synchronised, stays synchronised until reset
  p_sync_sticky_r1: assert property (@(posedge clk) disable iff (rst)
    synced_q |=> synced_q);

endmodule

// File: rtl/tdmw_window_decode.sv
module tdmw_window_decode
  import tdmw_pkg::*;
#(
  parameter int NUM_CHAN  = 32,
  parameter int CHAN_BITS = 8,
  localparam int CH_W = $clog2(NUM_CHAN),
  localparam int BT_W = $clog2(CHAN_BITS)
) (
  input  tc_code_t        code,
  input  logic [CH_W-1:0] chan,
  input  logic [BT_W-1:0] bitn,
  output logic            hit
);

  always_comb begin
    hit = slot_hit(code, int'(unsigned'(chan)), int'(unsigned'(bitn)));
  end

  // R7: the control channel is outside every window
  always_comb begin
    a_ctrl_chan_r7: assert (!(hit && chan == CH_W'(CTRL_CHAN)));
  end

endmodule

// File: rtl/tdm_window_gen.sv
module tdm_window_gen
  import tdmw_pkg::*;
#(
  parameter int NUM_CHAN  = 32,
  parameter int CHAN_BITS = 8,
  localparam int CH_W = $clog2(NUM_CHAN),
  localparam int BT_W = $clog2(CHAN_BITS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            frame_pulse,
  input  logic [3:0]      ctrl_code,
  output logic            tx_en,
  output logic            rx_en,
  output logic            out_en,
  output logic [CH_W-1:0] chan_idx,
  output logic [BT_W-1:0] bit_idx
);

  logic [CH_W-1:0] chan_d;
  logic [BT_W-1:0] bit_d;
  logic            boundary;
  tc_code_t        code_q, code_d;
  logic            synced_q, synced_d;
  logic            hit_d;

  tdmw_slot_counter #(.NUM_CHAN(NUM_CHAN), .CHAN_BITS(CHAN_BITS)) u_cnt (
    .clk(clk), .rst(rst), .frame_pulse(frame_pulse),
    .chan_q(chan_idx), .bit_q(bit_idx),
    .chan_d(chan_d), .bit_d(bit_d), .boundary(boundary)
  );

  tdmw_code_latch u_code (
    .clk(clk), .rst(rst), .frame_pulse(frame_pulse), .boundary(boundary),
    .code_in(ctrl_code), .code_q(code_q), .code_d(code_d),
    .synced_q(synced_q), .synced_d(synced_d)
  );

  tdmw_window_decode #(.NUM_CHAN(NUM_CHAN), .CHAN_BITS(CHAN_BITS)) u_dec (
    .code(code_d), .chan(chan_d), .bitn(bit_d), .hit(hit_d)
  );

  // registered strobes aligned with the registered indices
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_en  <= 1'b0;
      rx_en  <= 1'b0;
      out_en <= 1'b0;
    end else begin
      tx_en  <= synced_d & hit_d;
      rx_en  <= synced_d & hit_d;
      out_en <= synced_d & hit_d;
    end
  end

  // R7: no strobe on the control channel
  p_no_ctrl_chan_r7: assert property (@(posedge clk) disable iff (rst)
    (tx_en || rx_en || out_en) |-> (chan_idx != CH_W'(CTRL_CHAN)));

  // R8: the three strobes move together
  p_strobes_match_r8: assert property (@(posedge clk) disable iff (rst)
    (rx_en == tx_en) && (out_en == tx_en));

  // R1: silent until the first frame pulse
  p_quiet_unsynced_r1: assert property (@(posedge clk) disable iff (rst)
    !synced_q |-> !tx_en);

  // R4: the last bit of the partial channel is never enabled
  p_sub_limit_r4: assert property (@(posedge clk) disable iff (rst)
    (tx_en && chan_idx == CH_W'(SUB_CHAN)) |-> (bit_idx != BT_W'(CHAN_BITS - 1)));

endmodule

// File: tb/sim_tdm_window_gen.sv
`timescale 1ns/1ps
module sim_tdm_window_gen;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frame_pulse = 1'b0;
  logic [3:0] ctrl_code = 4'd0;
  logic       tx_en, rx_en, out_en;
  logic [4:0] chan_idx;
  logic [2:0] bit_idx;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  tdm_window_gen u0 (
    .clk(clk), .rst(rst), .frame_pulse(frame_pulse), .ctrl_code(ctrl_code),
    .tx_en(tx_en), .rx_en(rx_en), .out_en(out_en),
    .chan_idx(chan_idx), .bit_idx(bit_idx)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected window membership from the requirements
  function automatic bit exp_win(input logic [3:0] code, input int pos);
    int ch, b;
    ch = pos / 8;
    b  = pos % 8;
    case (code[2:0])
      3'd0: return ch == 0 && b == 0;
      3'd1: return ch == 0 && b <= 1;
      3'd2: return ch == 0 && b <= (code[3] ? 6 : 5);
      3'd3: return ch == 2;
      3'd4: return ch == 3;
      3'd5: return ch == 4;
      3'd6: return ch == 2 || ch == 3;
      default: return ch >= 2 && ch <= 4;
    endcase
  endfunction

  function automatic int exp_count(input logic [3:0] code);
    int c = 0;
    for (int p = 0; p < 256; p++) c += int'(exp_win(code, p));
    return c;
  endfunction

  // Walk nfr frames from a pulse; code 'first' in frame 0, 'second' driven
  // after position chg_at (takes effect at the wrap).
  task automatic walk(input logic [3:0] first, input logic [3:0] second,
                      input int chg_at, input int nfr, input string req);
    int idx_err = 0, win_err = 0, ch1_err = 0, lane_err = 0, cnt = 0;
    logic [3:0] cur;
    @(negedge clk);
    ctrl_code = first;
    frame_pulse = 1'b1;
    @(negedge clk);
    frame_pulse = 1'b0;
    for (int i = 0; i < 256 * nfr; i++) begin
      int p = i % 256;
      cur = (i < 256) ? first : second;
      if (chan_idx != 5'(p / 8) || bit_idx != 3'(p % 8)) idx_err++;
      if (tx_en != exp_win(cur, p)) win_err++;
      if (tx_en && chan_idx == 5'd1) ch1_err++;
      if (rx_en != tx_en || out_en != tx_en) lane_err++;
      if (i < 256) cnt += int'(tx_en);
      if (i == chg_at) ctrl_code = second;
      @(negedge clk);
    end
    chk(idx_err == 0, "R2 index sequence", idx_err, 0);
    chk(win_err == 0, req, win_err, 0);
    chk(cnt == exp_count(first), {req, " bit count"}, cnt, exp_count(first));
    chk(ch1_err == 0, "R7 channel 1 quiet", ch1_err, 0);
    chk(lane_err == 0, "R8 strobes equal", lane_err, 0);
  endtask

  task automatic t_reset();
    int hi = 0;
    rst = 1'b1;
    ctrl_code = 4'd7;
    repeat (3) @(negedge clk);
    chk(!tx_en && !rx_en && !out_en, "R1 enables in reset", int'(tx_en), 0);
    chk(chan_idx == 0 && bit_idx == 0, "R1 index in reset", int'(chan_idx), 0);
    rst = 1'b0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      hi += int'(tx_en | rx_en | out_en);
    end
    chk(hi == 0, "R1 quiet before first pulse", hi, 0);
  endtask

  task automatic t_codes();
    for (int c = 0; c < 16; c++) begin
      string r;
      case (c % 8)
        0, 1:    r = "R3 partial window";
        2:       r = "R4 six/seven bit window";
        3, 4, 5: r = "R5 single channel";
        default: r = "R6 channel run";
      endcase
      if (c >= 8 && c != 10) r = {r, " / R10 top bit ignored"};
      walk(4'(c), 4'(c), -1, 1, r);
    end
  endtask

  task automatic t_switch();
    walk(4'd3, 4'd5, 10, 2, "R9 change at boundary");
    walk(4'd2, 4'd10, 3, 2, "R9 partial width change");
  endtask

  task automatic t_resync();
    int bad = 0;
    walk(4'd7, 4'd7, -1, 1, "R6 before resync");
    repeat (99) @(negedge clk);
    frame_pulse = 1'b1;
    @(negedge clk);
    frame_pulse = 1'b0;
    chk(chan_idx == 0 && bit_idx == 0, "R2 mid-frame pulse restarts", int'(chan_idx), 0);
    for (int i = 1; i < 40; i++) begin
      @(negedge clk);
      if (tx_en != exp_win(4'd7, i)) bad++;
    end
    chk(bad == 0, "R2 window after resync", bad, 0);
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_codes();
    t_switch();
    t_resync();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

endmodule